// File: doc/BRIEF.md
# Hold-Gated Selectable Clock Divider

This block produces a system clock by dividing a free-running fast source clock by 2, 4, 8 or 16, picked by a 2-bit select. A single active-high hold input stands for any reason to stop the machine: system reset, the run/stop switch in its stop position, or a program loader owning memory. While hold is present the source keeps toggling, but the divider count is pinned at zero and the divided output is parked low.

Because the count restarts from zero on every release, the first edge the downstream logic sees is always a rising edge. Its first microcode step is never skipped, whatever phase the source clock was in when hold dropped. Hold arrives asynchronously, so it passes through a two-flop synchronizer first. A select change made while the divider runs is deferred to the next wrap of the counter, so that no short pulse reaches the output.

Top module: `divclk_gen`

## Requirements
- R1: With hold inactive, sel_i values 0, 1, 2 and 3 give an output period of 2, 4, 8 and 16 source cycles, with high and low phases each lasting 2^sel_i source cycles.
- R2: Once the synchronized hold is active, clk_o is low and stays low, and the divider count is zero, for as long as hold stays active.
- R3: hold_i passes through two source-clock flops. A hold_i level sampled at rising source edge t acts on clk_o at edge t+2, and clk_o is unchanged by it at edge t+1.
- R4: After hold releases, the first transition of clk_o is a rising edge. It occurs at source edge t+1+2^sel_i, where t is the first rising source edge that samples hold_i low.
- R5: clk_o changes only on rising source edges. A release made while the source clock is high is first sampled at the following rising edge, so its first output rise obeys the same count as a release made while the source clock is low.
- R6: A sel_i change while running takes effect only when the 4-bit count wraps from 15 to 0. Every output phase lasts 2^sel for the ratio in force, and the first phase under a new ratio is low.
- R7: While rst_ni is low, clk_o is low and the synchronizer reads as hold. If hold_i is low when rst_ni rises, the first rising source edge after that counts as edge t for R4.
- R8: A sel_i value set while hold is active is in force from the first output phase after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Asynchronous hold request (reset, stop or loader active) |
| sel_i | input | 2 | Divide select: 0 to 3 gives divide by 2, 4, 8, 16 |
| clk_o | output | 1 | Divided system clock, low while held |

## Verification
Every ratio is released twice, once in the low phase of the source and once in its high phase, and the edge count to the first rise is measured. A divider that merely gated its output, without clearing its count, would show a falling edge or a short first high phase here. A design that reacted to the source level would give different counts for the two release phases. A select switch from divide-by-2 to divide-by-16 while running shows any mid-count switch as a phase length other than 1 or 8. Hold applied in the middle of a long high phase checks the two-edge latency and that the output then stays low.

// File: rtl/divclk_pkg.sv
package divclk_pkg;
  localparam int unsigned DIV_CNT_W   = 4;
  localparam int unsigned DIV_SYNC_N  = 2;
endpackage

// File: rtl/divclk_hold_sync.sv
module divclk_hold_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic hold_o
);
  logic [STAGES-1:0] chain_q;
  logic [3:0]        warm_q;

  // reset presets the chain to "held"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], hold_i};
  end

  assign hold_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 4'hf)  warm_q <= warm_q + 4'd1;
  end

  // R3
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(warm_q) >= STAGES) |-> (hold_o == $past(hold_i, STAGES)));
endmodule

// File: rtl/divclk_counter.sv
module divclk_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  output logic [W-1:0] cnt_nxt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign cnt_nxt_o = clear_i ? '0 : cnt_q + 1'b1;
  assign wrap_o    = !clear_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  // R2
  held_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/divclk_tap.sv
module divclk_tap #(
  parameter int unsigned W     = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             wrap_i,
  input  logic [W-1:0]     cnt_nxt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o
);
  logic [SEL_W-1:0] sel_act_q, sel_nxt;
  logic             clk_q, clk_nxt;

  // select only reloads at wrap or while held: no runt phase
  assign sel_nxt = (hold_i || wrap_i) ? sel_i : sel_act_q;
  assign clk_nxt = hold_i ? 1'b0 : cnt_nxt_i[sel_nxt];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_act_q <= '0;
      clk_q     <= 1'b0;
    end else begin
      sel_act_q <= sel_nxt;
      clk_q     <= clk_nxt;
    end
  end

  assign clk_o = clk_q;

  // phase tracking for checks
  logic [W:0] ph_q;
  logic       clean_q, started_q, chg;

  assign chg = !hold_i && (clk_nxt != clk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      clean_q   <= 1'b0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (chg)              ph_q <= {{W{1'b0}}, 1'b1};
      else if (ph_q != '1)  ph_q <= ph_q + 1'b1;
      if (hold_i)           clean_q <= 1'b0;
      else if (chg)         clean_q <= 1'b1;
    end
  end

  // R1 R6
  phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && clean_q) |-> (ph_q == ({{W{1'b0}}, 1'b1} << sel_act_q)));

  // R4
  first_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && !clean_q) |-> !clk_q);

  // R6
  new_ratio_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && (sel_act_q != $past(sel_act_q)) && !$past(hold_i)) |-> !clk_o);

  // R8
  sel_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $fell(hold_i)) |-> (sel_act_q == $past(sel_i)));
endmodule

// File: rtl/divclk_gen.sv
module divclk_gen #(
  parameter int unsigned CNT_W       = divclk_pkg::DIV_CNT_W,
  parameter int unsigned SEL_W       = $clog2(CNT_W),
  parameter int unsigned SYNC_STAGES = divclk_pkg::DIV_SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o
);
  logic             hold_q;
  logic             wrap;
  logic [CNT_W-1:0] cnt_nxt;

  divclk_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .hold_o (hold_q)
  );

  divclk_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (hold_q),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  divclk_tap #(.W(CNT_W), .SEL_W(SEL_W)) u_tap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold_q),
    .wrap_i    (wrap),
    .cnt_nxt_i (cnt_nxt),
    .sel_i     (sel_i),
    .clk_o     (clk_o)
  );

  // R2
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |=> !clk_o);

  // R4
  release_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> !clk_o);
endmodule

// File: tb/divclk_gen_bench.sv
module divclk_gen_bench;
  logic       clk_i  = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hold_i = 1'b0;
  logic [1:0] sel_i  = 2'd0;
  logic       clk_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  divclk_gen u_divclk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .sel_i  (sel_i),
    .clk_o  (clk_o)
  );

  // vectors: select, release in source-high phase, expected half period, expected first-rise edge
  localparam int NV = 8;
  localparam int VEC_SEL  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam bit VEC_HI   [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
  localparam int VEC_HALF [NV] = '{1, 2, 4, 8, 1, 2, 4, 8};
  localparam int VEC_RISE [NV] = '{3, 4, 6, 10, 3, 4, 6, 10};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // edges until clk_o leaves its present level, sampled at falling source edges
  task automatic phase_len(output int len, output bit lvl);
    lvl = clk_o;
    len = 0;
    do begin
      @(posedge clk_i);
      @(negedge clk_i);
      len++;
    end while (clk_o == lvl && len < 40);
  endtask

  task automatic release_hold(input bit at_high);
    if (at_high) begin
      @(posedge clk_i); #2;
    end else begin
      @(negedge clk_i); #1;
    end
    hold_i = 1'b0;
  endtask

  // edges from release to first high sample
  task automatic count_rise(output int n, output bit fell_first);
    n = 0;
    fell_first = 1'b0;
    do begin
      @(posedge clk_i);
      @(negedge clk_i);
      n++;
    end while (!clk_o && n < 40);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n, len;
    bit lvl, dummy;

    // R7: reset state and first edge after reset
    repeat (3) @(negedge clk_i);
    chk(clk_o == 1'b0, "R7 low in reset", clk_o, 0);
    @(negedge clk_i); #1;
    rst_ni = 1'b1;
    count_rise(n, dummy);
    chk(n == 3, "R7 first rise after reset", n, 3);

    // R1 R4 R5: table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i); #1;
      hold_i = 1'b1;
      repeat (4) @(negedge clk_i);
      sel_i = 2'(VEC_SEL[v]);
      repeat (2) @(negedge clk_i);
      release_hold(VEC_HI[v]);
      count_rise(n, dummy);
      chk(n == VEC_RISE[v], VEC_HI[v] ? "R5 first rise, release in high" : "R4 first rise", n, VEC_RISE[v]);
      for (int p = 0; p < 4; p++) begin
        phase_len(len, lvl);
        chk(len == VEC_HALF[v], "R1 phase length", len, VEC_HALF[v]);
      end
    end

    // R6: switch from divide-by-2 to divide-by-16 while running
    @(negedge clk_i); #1;
    hold_i = 1'b1;
    sel_i  = 2'd0;
    repeat (4) @(negedge clk_i);
    release_hold(1'b0);
    repeat (9) @(negedge clk_i);
    #1;
    sel_i = 2'd3;
    begin
      int long_n;
      bit first_long_seen, first_long_low, bad;
      long_n = 0; first_long_seen = 0; first_long_low = 0; bad = 0;
      for (int p = 0; p < 24; p++) begin
        phase_len(len, lvl);
        if (len != 1 && len != 8) begin
          bad = 1;
          chk(1'b0, "R6 phase length", len, 8);
        end
        if (len == 8) begin
          if (!first_long_seen) first_long_low = !lvl;
          first_long_seen = 1;
          long_n++;
        end
      end
      chk(!bad, "R6 no runt phase", bad, 0);
      chk(long_n >= 2, "R6 new ratio applied", long_n, 2);
      chk(first_long_low, "R6 new ratio starts low", first_long_low, 1);
    end

    // R3 R2: hold during a long high phase
    do @(negedge clk_i); while (!clk_o);
    do @(negedge clk_i); while (clk_o);
    do @(negedge clk_i); while (!clk_o);
    #1;
    hold_i = 1'b1;
    @(negedge clk_i);
    chk(clk_o == 1'b1, "R3 no effect at edge t", clk_o, 1);
    @(negedge clk_i);
    chk(clk_o == 1'b1, "R3 no effect at edge t+1", clk_o, 1);
    @(negedge clk_i);
    chk(clk_o == 1'b0, "R3 low at edge t+2", clk_o, 0);
    begin
      int highs;
      highs = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk_i);
        if (clk_o) highs++;
      end
      chk(highs == 0, "R2 stays low while held", highs, 0);
    end

    // R8: select changed during hold applies from release
    sel_i = 2'd0;
    repeat (3) @(negedge clk_i);
    sel_i = 2'd2;
    repeat (3) @(negedge clk_i);
    release_hold(1'b0);
    count_rise(n, dummy);
    chk(n == 6, "R8 first rise with held select", n, 6);
    phase_len(len, lvl);
    chk(len == 4, "R8 high phase with held select", len, 4);
    phase_len(len, lvl);
    chk(len == 4, "R8 low phase with held select", len, 4);

    summary();
  end
endmodule